// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects interrupt requests from eight lines and presents one interrupt signal to a processor. Each line has a fixed priority. Line 0 is the most urgent and line 7 the least. A rising edge on a line records a pending request. The controller raises its interrupt output whenever a pending, unmasked line is more urgent than every line already being serviced.

When the processor acknowledges, the controller picks the most urgent such line and moves it from pending to in-service. It then presents that line's 3-bit index for one cycle. A per-line cascade-enable input is carried out beside the index, so that a line fed by a downstream controller can be recognised.

An in-service line blocks itself and every less urgent line. The block lasts until the handler issues a non-specific end-of-interrupt command, which retires the most urgent in-service line. A small write port carries two commands: one loads the mask, the other issues the end-of-interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `irq_req_i[i]` (low in one clock cycle, high in the next) sets the pending bit of line i. The bit stays set while the line is held or dropped, until the line is acknowledged.
- R2: `irq_o` is high exactly when some pending, unmasked line has a lower index than every in-service line. When nothing is in service, any pending, unmasked line qualifies.
- R3: An `ack_i` in a cycle where `irq_o` is high selects the lowest-index qualifying line. In the next cycle `vec_vld_o` is high and `vec_idx_o` holds that line's index (binary 0 to 7). The selected line's pending bit is cleared and its in-service bit is set.
- R4: `vec_vld_o` stays high for one cycle per acknowledge. An `ack_i` while `irq_o` is low changes no state and produces no `vec_vld_o`.
- R5: While line k is in service, pending lines with index k or higher do not raise `irq_o`. A pending line with an index below k does raise it.
- R6: A write with `wr_cmd_i` = 2 (end-of-interrupt) clears only the lowest-index in-service bit. Other in-service bits stay set.
- R7: A write with `wr_cmd_i` = 1 replaces the mask with `wr_data_i`, where bit i masks line i. A masked line can become pending but is never selected. Clearing its mask bit makes it selectable again.
- R8: A write with `wr_cmd_i` = 0 or 3, and any cycle with `wr_en_i` low, leaves the mask and the in-service state unchanged.
- R9: `vec_casc_o` equals `casc_en_i` of the selected line, in the cycle in which `vec_vld_o` is high.
- R10: Driving `rst_n` low clears pending, in-service and mask state at once, and drives `irq_o` and `vec_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req_i | input | 8 | Interrupt request lines; a rising edge records a request |
| casc_en_i | input | 8 | Per-line flag marking a line fed by a downstream controller |
| wr_en_i | input | 1 | Command write strobe |
| wr_cmd_i | input | 2 | Command: 1 = load mask, 2 = end-of-interrupt, 0 and 3 = no effect |
| wr_data_i | input | 8 | Mask value for the load-mask command |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | One-cycle strobe: an index is presented |
| vec_idx_o | output | 3 | Index of the acknowledged line |
| vec_casc_o | output | 1 | Cascade flag of the acknowledged line |

## Verification
The hardest situation to reach is nested service. Two lines must be in service at once, with pending lines on both sides of them. Only then can the end-of-interrupt be shown to retire just the more urgent level while the less urgent level keeps blocking. The stimulus table gets there in stages. It acknowledges line 3, then posts edges on line 7 and again on line 3 to show both are held off. It then raises line 1 and acknowledges it, which nests it over line 3. Two end-of-interrupt writes then unwind the nest one level at a time.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_MASK = 2'd1,
    CMD_EOI  = 2'd2,
    CMD_RSV  = 2'd3
  } irq_cmd_e;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);

  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;
  logic [N_LINES-1:0] rise;

  always_comb begin
    rise   = req_i & ~req_q;
    // a fresh edge wins over a same-cycle acknowledge clear
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] cand_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_LINES-1:0] oh_o
);

  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = '0;
        oh_o[i] = 1'b1;
      end
    end
    any_o = |cand_i;
  end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_i,
  input  logic               eoi_i,
  output logic [N_LINES-1:0] isr_o,
  output logic [N_LINES-1:0] blk_o
);

  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] isr_d;
  logic [N_LINES-1:0] eoi_clr;
  logic               found;

  always_comb begin
    eoi_clr = '0;
    found   = 1'b0;
    for (int i = 0; i < N_LINES; i++) begin
      if (isr_q[i] && !found) begin
        eoi_clr[i] = 1'b1;
        found      = 1'b1;
      end
    end
    isr_d = (isr_q & ~(eoi_clr & {N_LINES{eoi_i}})) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      isr_q <= isr_d;
    end
  end

  // line i is blocked when it or any more urgent line is in service
  assign blk_o[0] = isr_q[0];
  for (genvar g = 1; g < N_LINES; g++) begin : g_blk
    assign blk_o[g] = blk_o[g-1] | isr_q[g];
  end

  assign isr_o = isr_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req_i,
  input  logic [N_LINES-1:0] casc_en_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_cmd_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic               vec_vld_o,
  output logic [IDX_W-1:0]   vec_idx_o,
  output logic               vec_casc_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mask_d;
  logic               mask_en;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] isr;
  logic [N_LINES-1:0] blk;
  logic [N_LINES-1:0] cand;
  logic               any_cand;
  logic [IDX_W-1:0]   sel_idx;
  logic [N_LINES-1:0] sel_oh;
  logic               take;
  logic [N_LINES-1:0] take_oh;
  logic               eoi;
  logic               vld_q;
  logic [IDX_W-1:0]   idx_q;
  logic               casc_q;
  logic               vld_d;
  logic [IDX_W-1:0]   idx_d;
  logic               casc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  irq_req_latch #(.N_LINES(N_LINES)) u_latch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (irq_req_i),
    .clr_i  (take_oh),
    .pend_o (pend)
  );

  irq_svc_track #(.N_LINES(N_LINES)) u_track (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (take_oh),
    .eoi_i (eoi),
    .isr_o (isr),
    .blk_o (blk)
  );

  irq_prio_pick #(.N_LINES(N_LINES)) u_pick (
    .cand_i (cand),
    .any_o  (any_cand),
    .idx_o  (sel_idx),
    .oh_o   (sel_oh)
  );

  always_comb begin
    cand    = pend & ~mask_q & ~blk;
    take    = ack_i & any_cand;
    take_oh = sel_oh & {N_LINES{take}};
    eoi     = wr_en_i && (irq_cmd_e'(wr_cmd_i) == CMD_EOI);
    mask_en = wr_en_i && (irq_cmd_e'(wr_cmd_i) == CMD_MASK);
    mask_d  = wr_data_i;
    vld_d   = take;
    idx_d   = sel_idx;
    casc_d  = |(casc_en_i & sel_oh);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (take) begin
        idx_q  <= idx_d;
        casc_q <= casc_d;
      end
    end
  end

  assign irq_o      = any_cand;
  assign vec_vld_o  = vld_q;
  assign vec_idx_o  = idx_q;
  assign vec_casc_o = casc_q & vld_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_cmd_i,
  input logic               irq_o,
  input logic               vec_vld_o,
  input logic [IDX_W-1:0]   vec_idx_o,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] isr
);

  // R2
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend & ~mask)));

  // R4
  vld_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> $past(ack_i && irq_o));

  // R3
  vld_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> ((isr >> vec_idx_o) & N_LINES'(1)) != '0);

  // R7
  vld_not_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> (($past(mask) >> vec_idx_o) & N_LINES'(1)) == '0);

  // R6
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_cmd_i == 2'd2 && !ack_i && isr != '0)
      |=> ($countones(isr) + 1 == $countones($past(isr))));

  // R8
  isr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !(wr_en_i && wr_cmd_i == 2'd2)) |=> $stable(isr));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ack_i     (ack_i),
  .wr_en_i   (wr_en_i),
  .wr_cmd_i  (wr_cmd_i),
  .irq_o     (irq_o),
  .vec_vld_o (vec_vld_o),
  .vec_idx_o (vec_idx_o),
  .pend      (pend),
  .mask      (mask_q),
  .isr       (isr)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  typedef struct packed {
    logic [7:0] req;
    logic       wen;
    logic [1:0] cmd;
    logic [7:0] wdata;
    logic       ack;
    logic       e_irq;
    logic       e_vld;
    logic [2:0] e_idx;
    logic       e_casc;
    logic [3:0] rq;
  } row_t;

  localparam int NROWS = 21;
  localparam row_t TBL [NROWS] = '{
    '{8'h08, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd1},  // R1 line 3 edge
    '{8'h08, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 4'd3},  // R3 ack line 3
    '{8'h80, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 lower blocked
    '{8'h88, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 equal blocked
    '{8'h02, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 higher passes
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 4'd3},  // R3 nest line 1
    '{8'h00, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 retire 1, 3 stays
    '{8'h00, 1'b1, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 retire 3
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 4'd2},  // R2 line 3 again
    '{8'h00, 1'b1, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 line 7 left
    '{8'h00, 1'b1, 2'd1, 8'h80, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 mask line 7
    '{8'h20, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 line 5 free
    '{8'h20, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 4'd9},  // R9 cascade flag
    '{8'h00, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 masked pending
    '{8'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 unmask
    '{8'h00, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd8},  // R8 cmd 3
    '{8'h00, 1'b1, 2'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd8},  // R8 cmd 0
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd7, 1'b0, 4'd9},  // R9 no cascade
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd4},  // R4 stray ack
    '{8'h01, 1'b0, 2'd1, 8'hFF, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd8},  // R8 wen low
    '{8'h01, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 4'd3}   // R3 line 0 over 7
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] irq_req_i;
  logic [7:0] casc_en_i;
  logic       wr_en_i;
  logic [1:0] wr_cmd_i;
  logic [7:0] wr_data_i;
  logic       ack_i;
  logic       irq_o;
  logic       vec_vld_o;
  logic [2:0] vec_idx_o;
  logic       vec_casc_o;

  int checks;
  int errors;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req_i  (irq_req_i),
    .casc_en_i  (casc_en_i),
    .wr_en_i    (wr_en_i),
    .wr_cmd_i   (wr_cmd_i),
    .wr_data_i  (wr_data_i),
    .ack_i      (ack_i),
    .irq_o      (irq_o),
    .vec_vld_o  (vec_vld_o),
    .vec_idx_o  (vec_idx_o),
    .vec_casc_o (vec_casc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act {irq,vld,idx}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    irq_req_i = '0;
    casc_en_i = 8'h20;
    wr_en_i = 1'b0;
    wr_cmd_i = 2'd0;
    wr_data_i = '0;
    ack_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {irq_o, vec_vld_o, 3'd0}, 5'b00000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      irq_req_i = TBL[i].req;
      wr_en_i   = TBL[i].wen;
      wr_cmd_i  = TBL[i].cmd;
      wr_data_i = TBL[i].wdata;
      ack_i     = TBL[i].ack;
      @(negedge clk);
      chk($sformatf("R%0d row %0d", TBL[i].rq, i),
          {irq_o, vec_vld_o, vec_vld_o ? vec_idx_o : 3'd0},
          {TBL[i].e_irq, TBL[i].e_vld, TBL[i].e_vld ? TBL[i].e_idx : 3'd0});
      if (TBL[i].e_vld) begin
        checks++;
        if (vec_casc_o !== TBL[i].e_casc) begin
          errors++;
          $display("FAIL R9 row %0d casc act=%b exp=%b", i, vec_casc_o, TBL[i].e_casc);
        end
      end
    end

    // R4 vector strobe drops after one cycle
    irq_req_i = '0;
    ack_i = 1'b0;
    @(negedge clk);
    chk("R4 strobe width", {irq_o, vec_vld_o, 3'd0}, 5'b00000);

    // R10 asynchronous reset with pending work and a full mask
    wr_en_i = 1'b1; wr_cmd_i = 2'd1; wr_data_i = 8'hFF;
    @(negedge clk);
    wr_en_i = 1'b0; wr_cmd_i = 2'd0;
    wr_en_i = 1'b1; wr_cmd_i = 2'd2;
    @(negedge clk);
    wr_en_i = 1'b0; wr_cmd_i = 2'd0;
    irq_req_i = 8'h04;
    @(negedge clk);
    chk("R7 all masked", {irq_o, vec_vld_o, 3'd0}, 5'b00000);
    #1 rst_n = 1'b0;
    #1 chk("R10 async clear", {irq_o, vec_vld_o, 3'd0}, 5'b00000);
    irq_req_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pending cleared", {irq_o, vec_vld_o, 3'd0}, 5'b00000);
    irq_req_i = 8'h10;
    @(negedge clk);
    // mask was cleared by reset, so line 4 is selectable
    chk("R10 mask cleared", {irq_o, vec_vld_o, 3'd0}, 5'b10000);
    irq_req_i = '0;
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk("R3 line 4 after reset", {irq_o, vec_vld_o, vec_idx_o}, 5'b01100);

    finish_run();
  end

endmodule